// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block keeps the page select byte for a paged special-function register space. The other registers decode their addresses against the page number it drives. The active page is the top entry of a short hardware stack. Software can read and write the top entry through the CPU register bus. Only the interrupt-acknowledge and return-from-interrupt pulses push or pop the stack.

When an interrupt is taken, the current page is saved. If auto-paging is enabled, the page is also forced to zero, so the service routine starts in a known page. On return, the page saved at that entry comes back. A control register holds the auto-paging enable. That register is only reachable while the active page is 0x0F.

Top module: `rps_page_ctrl`

## Requirements
- R1: After reset the active page is 0x00, the auto-paging enable is 1 and no pages are saved.
- R2: The page select register at address 0xA7 answers on every page. A read returns the active page. A write replaces the active page after the clock edge and saves nothing. Read data is registered: it appears one edge after the address is presented.
- R3: The control register at address 0xE5 is visible only while the active page is 0x0F. Its bit 0 is the auto-paging enable. Bits 7 to 1 read as zero and ignore writes. On any other page a write to 0xE5 has no effect and a read returns 0x00.
- R4: With auto-paging enabled, an interrupt acknowledge sets the active page to 0x00 at the next edge and saves the previous page.
- R5: With auto-paging disabled, an interrupt acknowledge leaves the active page unchanged but still saves a copy of it, so the matching return restores that copy.
- R6: A return from interrupt restores the most recently saved page. Saves are undone in last-in, first-out order across two nesting levels.
- R7: At most two pages are saved. An acknowledge with two pages saved discards the oldest one. A return with nothing saved leaves the active page unchanged.
- R8: A page select write in the same cycle as an acknowledge or return is held back. The stack operation happens first, and the written value replaces the new active page one edge later.
- R9: An acknowledge and a return in the same cycle cancel. The active page and the saved pages stay as they were.
- R10: Addresses other than the two registers read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Register bus write strobe |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq_ack | input | 1 | Interrupt-acknowledge pulse |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| page_out | output | 8 | Active page number |

## Verification
The checker tests these properties on every cycle:
- the state after reset
- the forced zero page on an enabled acknowledge
- the unchanged page on a disabled acknowledge
- the no-op return when nothing is saved
- the bound on saved entries
- cancellation of simultaneous pulses
- the guard that protects the enable bit from writes while the page is not 0x0F

Some behaviour needs a history of several events, so only the bench scenarios can show it:
- the last-in, first-out order of restored pages
- loss of the oldest entry on overflow
- the hidden save made while auto-paging is off
- the deferred landing of a colliding write

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;

  function automatic stk_op_e pick_op(input logic ack, input logic ret);
    if (ack && ret) return OP_HOLD;
    if (ack)        return OP_PUSH;
    if (ret)        return OP_POP;
    return OP_HOLD;
  endfunction

endpackage

// File: rtl/rps_event_arb.sv
`timescale 1ns/1ps
module rps_event_arb
  import rps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_ack,
  input  logic              irq_ret,
  input  logic              page_we,
  input  logic [DATA_W-1:0] page_wdata,
  output stk_op_e           op,
  output logic              top_wr_en,
  output logic [DATA_W-1:0] top_wr_data
);

  logic              evt;
  logic              pend_vld;
  logic [DATA_W-1:0] pend_data;

  assign evt = irq_ack | irq_ret;
  assign op  = pick_op(irq_ack, irq_ret);

  // A page write that collides with a stack event is parked for one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_data <= '0;
    end else if (evt) begin
      if (page_we) begin
        pend_vld  <= 1'b1;
        pend_data <= page_wdata;
      end
    end else begin
      pend_vld <= 1'b0;
    end
  end

  // A fresh write wins over a parked one.
  assign top_wr_en   = !evt && (page_we || pend_vld);
  assign top_wr_data = page_we ? page_wdata : pend_data;

endmodule

// File: rtl/rps_page_stack.sv
`timescale 1ns/1ps
module rps_page_stack
  import rps_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  stk_op_e                    op,
  input  logic                       auto_en,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          top,
  output logic [$clog2(DEPTH)-1:0]   level
);

  localparam int              LVL_W   = $clog2(DEPTH);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH - 1);

  logic [DATA_W-1:0] ent [DEPTH];
  logic              can_pop;

  assign can_pop = (level != '0);

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      if (gi == 0) begin : g_top
        always_ff @(posedge clk) begin
          if (rst) begin
            ent[gi] <= '0;
          end else begin
            unique case (op)
              OP_PUSH: if (auto_en) ent[gi] <= '0;
              OP_POP:  if (can_pop) ent[gi] <= ent[gi+1];
              default: if (wr_en)   ent[gi] <= wr_data;
            endcase
          end
        end
      end else if (gi == DEPTH - 1) begin : g_bot
        always_ff @(posedge clk) begin
          if (rst) begin
            ent[gi] <= '0;
          end else begin
            unique case (op)
              OP_PUSH: ent[gi] <= ent[gi-1];
              OP_POP:  if (can_pop) ent[gi] <= '0;
              default: ;
            endcase
          end
        end
      end else begin : g_mid
        always_ff @(posedge clk) begin
          if (rst) begin
            ent[gi] <= '0;
          end else begin
            unique case (op)
              OP_PUSH: ent[gi] <= ent[gi-1];
              OP_POP:  if (can_pop) ent[gi] <= ent[gi+1];
              default: ;
            endcase
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else begin
      unique case (op)
        OP_PUSH: if (level != LVL_MAX) level <= level + 1'b1;
        OP_POP:  if (can_pop)          level <= level - 1'b1;
        default: ;
      endcase
    end
  end

  assign top = ent[0];

endmodule

// File: rtl/rps_ctrl_reg.sv
`timescale 1ns/1ps
module rps_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic sel_we,
  input  logic wbit,
  output logic auto_en
);

  always_ff @(posedge clk) begin
    if (rst)         auto_en <= 1'b1;
    else if (sel_we) auto_en <= wbit;
  end

endmodule

// File: rtl/rps_read_mux.sv
`timescale 1ns/1ps
module rps_read_mux #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'hA7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hE5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] top,
  input  logic              ctrl_vis,
  input  logic              auto_en,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == PAGE_ADDR)
      rd_next = top;
    else if (addr == CTRL_ADDR && ctrl_vis)
      rd_next = {{(DATA_W-1){1'b0}}, auto_en};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/rps_page_ctrl.sv
`timescale 1ns/1ps
module rps_page_ctrl
  import rps_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter int                DEPTH     = 3,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'hA7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hE5,
  parameter logic [DATA_W-1:0] CTRL_PAGE = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic [DATA_W-1:0] page_out
);

  localparam int LVL_W = $clog2(DEPTH);

  stk_op_e           op;
  logic              page_we;
  logic              ctrl_vis;
  logic              ctrl_we;
  logic              top_wr_en;
  logic [DATA_W-1:0] top_wr_data;
  logic              auto_en;
  logic [LVL_W-1:0]  level;

  assign page_we  = bus_we && (bus_addr == PAGE_ADDR);
  assign ctrl_vis = (page_out == CTRL_PAGE);
  assign ctrl_we  = bus_we && (bus_addr == CTRL_ADDR) && ctrl_vis;

  rps_event_arb #(.DATA_W(DATA_W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .irq_ack     (irq_ack),
    .irq_ret     (irq_ret),
    .page_we     (page_we),
    .page_wdata  (bus_wdata),
    .op          (op),
    .top_wr_en   (top_wr_en),
    .top_wr_data (top_wr_data)
  );

  rps_page_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .auto_en (auto_en),
    .wr_en   (top_wr_en),
    .wr_data (top_wr_data),
    .top     (page_out),
    .level   (level)
  );

  rps_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sel_we  (ctrl_we),
    .wbit    (bus_wdata[0]),
    .auto_en (auto_en)
  );

  rps_read_mux #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PAGE_ADDR (PAGE_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .top      (page_out),
    .ctrl_vis (ctrl_vis),
    .auto_en  (auto_en),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/rps_checker.sv
`timescale 1ns/1ps
module rps_checker #(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter int                DEPTH     = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hE5,
  parameter logic [DATA_W-1:0] CTRL_PAGE = 8'h0F
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     irq_ack,
  input logic                     irq_ret,
  input logic                     bus_we,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        page_out,
  input logic                     auto_en,
  input logic [$clog2(DEPTH)-1:0] level
);

  localparam int               LVL_W   = $clog2(DEPTH);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH - 1);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q && !rst) begin
      assert_reset_state_R1: assert (page_out == '0 && auto_en && level == '0)
        else $error("page state wrong right after reset");
    end
  end

  assert_auto_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_ret && auto_en) |=> (page_out == '0));

  assert_keep_page_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_ret && !auto_en) |=> $stable(page_out));

  assert_push_level_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !irq_ret && level != LVL_MAX) |=> (level == $past(level) + 1'b1));

  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && !irq_ack && level == '0) |=> ($stable(page_out) && level == '0));

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_MAX);

  assert_cancel_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_ret) |=> ($stable(page_out) && $stable(level)));

  assert_ctrl_guard_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == CTRL_ADDR && page_out == CTRL_PAGE) |=> $stable(auto_en));

endmodule

bind rps_page_ctrl rps_checker #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .DEPTH     (DEPTH),
  .CTRL_ADDR (CTRL_ADDR),
  .CTRL_PAGE (CTRL_PAGE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_ack  (irq_ack),
  .irq_ret  (irq_ret),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .page_out (page_out),
  .auto_en  (auto_en),
  .level    (level)
);

// File: tb/rps_page_ctrl_tb.sv
`timescale 1ns/1ps
module rps_page_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq_ret = 1'b0;
  logic [7:0] page_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rps_page_ctrl u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .page_out  (page_out)
  );

  typedef struct {
    bit         cp;
    logic [7:0] ep;
    bit         cr;
    logic [7:0] er;
    string      tag;
  } item_t;

  item_t sb_q[$];

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // Monitor: each edge produces the result of the item queued before it.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.cp) check(it.tag, "page_out", page_out, it.ep);
        if (it.cr) check(it.tag, "bus_rdata", bus_rdata, it.er);
      end
    end
  end

  task automatic step(input logic ack, input logic ret, input logic we,
                      input logic [7:0] addr, input logic [7:0] wd,
                      input bit cp, input logic [7:0] ep,
                      input bit cr, input logic [7:0] er, input string tag);
    item_t it;
    @(negedge clk);
    irq_ack = ack; irq_ret = ret; bus_we = we; bus_addr = addr; bus_wdata = wd;
    it.cp = cp; it.ep = ep; it.cr = cr; it.er = er; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [7:0] ep, input string tag);
    step(1'b0, 1'b0, 1'b1, a, d, 1'b1, ep, 1'b0, 8'h00, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] er, input logic [7:0] ep, input string tag);
    step(1'b0, 1'b0, 1'b0, a, 8'h00, 1'b1, ep, 1'b1, er, tag);
  endtask

  task automatic irq(input logic ack, input logic ret, input logic [7:0] ep, input string tag);
    step(ack, ret, 1'b0, 8'h00, 8'h00, 1'b1, ep, 1'b0, 8'h00, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "page_out after reset", page_out, 8'h00);

    // R1 / R2 / R3: register access
    rd(8'hA7, 8'h00, 8'h00, "R1 page reads zero");
    rd(8'hE5, 8'h00, 8'h00, "R3 control hidden on page 00");
    wr(8'hA7, 8'h0F, 8'h0F, "R2 write page");
    rd(8'hE5, 8'h01, 8'h0F, "R1 enable resets to 1");
    wr(8'hE5, 8'hFF, 8'h0F, "R3 write all ones");
    rd(8'hE5, 8'h01, 8'h0F, "R3 reserved bits read zero");
    wr(8'hE5, 8'hFE, 8'h0F, "R3 clear enable");
    rd(8'hE5, 8'h00, 8'h0F, "R3 enable cleared");
    wr(8'hE5, 8'h01, 8'h0F, "R3 set enable");
    wr(8'hA7, 8'h22, 8'h22, "R2 write page 22");
    wr(8'hE5, 8'h00, 8'h22, "R3 write off page");
    rd(8'hE5, 8'h00, 8'h22, "R3 read off page");
    rd(8'hA7, 8'h22, 8'h22, "R2 page readable from any page");
    wr(8'hA7, 8'h0F, 8'h0F, "R2 back to 0F");
    rd(8'hE5, 8'h01, 8'h0F, "R3 off-page write ignored");
    wr(8'h10, 8'h55, 8'h0F, "R10 unmapped write");
    rd(8'h10, 8'h00, 8'h0F, "R10 unmapped read");

    // R4 / R6 / R7: nesting with auto-paging on
    irq(1'b1, 1'b0, 8'h00, "R4 entry forces zero");
    wr(8'hA7, 8'h33, 8'h33, "R2 in-place write in handler");
    irq(1'b1, 1'b0, 8'h00, "R4 nested entry");
    irq(1'b0, 1'b1, 8'h33, "R6 inner return");
    irq(1'b0, 1'b1, 8'h0F, "R6 outer return");
    irq(1'b0, 1'b1, 8'h0F, "R7 return with nothing saved");

    // R7: overflow drops the oldest
    wr(8'hA7, 8'h41, 8'h41, "R2");
    irq(1'b1, 1'b0, 8'h00, "R4");
    wr(8'hA7, 8'h42, 8'h42, "R2");
    irq(1'b1, 1'b0, 8'h00, "R4");
    wr(8'hA7, 8'h43, 8'h43, "R2");
    irq(1'b1, 1'b0, 8'h00, "R7 push when full");
    irq(1'b0, 1'b1, 8'h43, "R7 newest restored");
    irq(1'b0, 1'b1, 8'h42, "R7 second restored");
    irq(1'b0, 1'b1, 8'h42, "R7 oldest was dropped");

    // R5: auto-paging off still saves
    wr(8'hA7, 8'h0F, 8'h0F, "R2");
    wr(8'hE5, 8'h00, 8'h0F, "R3 disable");
    wr(8'hA7, 8'h50, 8'h50, "R2");
    irq(1'b1, 1'b0, 8'h50, "R5 page kept on entry");
    wr(8'hA7, 8'h51, 8'h51, "R2");
    irq(1'b0, 1'b1, 8'h50, "R5 saved copy restored");
    irq(1'b0, 1'b1, 8'h50, "R5 write did not push");

    // R8: colliding writes
    wr(8'hA7, 8'h0F, 8'h0F, "R2");
    wr(8'hE5, 8'h01, 8'h0F, "R3 enable");
    wr(8'hA7, 8'h60, 8'h60, "R2");
    step(1'b1, 1'b0, 1'b1, 8'hA7, 8'h77, 1'b1, 8'h00, 1'b0, 8'h00, "R8 entry first");
    irq(1'b0, 1'b0, 8'h77, "R8 deferred write lands");
    irq(1'b0, 1'b1, 8'h60, "R6 return after deferred write");
    irq(1'b1, 1'b0, 8'h00, "R4");
    step(1'b0, 1'b1, 1'b1, 8'hA7, 8'h88, 1'b1, 8'h60, 1'b0, 8'h00, "R8 return first");
    irq(1'b0, 1'b0, 8'h88, "R8 deferred write lands");
    irq(1'b0, 1'b1, 8'h88, "R7 nothing saved");

    // R9: simultaneous pulses cancel
    irq(1'b1, 1'b0, 8'h00, "R4");
    irq(1'b1, 1'b1, 8'h00, "R9 page unchanged");
    irq(1'b0, 1'b1, 8'h88, "R9 one entry saved");
    irq(1'b0, 1'b1, 8'h88, "R9 no extra entry");

    irq(1'b0, 1'b0, 8'h88, "idle");
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule